// File: doc/BRIEF.md
# ARINC 429 Word Transmitter with Eight-Word Queue

This block takes 31-bit ARINC 429 words from a 16-bit host bus, queues up to eight of them and sends them as return-to-zero serial words on two digital line outputs. One output pulses for a ONE bit and the other for a ZERO bit; an external line driver turns them into bus levels. Each word is loaded in two strobes: a low half, then a high half that commits the word. While the enable input is high, queued words go out back to back with a word gap between them. Bit 32 carries odd or even parity, or a data bit the host supplied.

A small control register chooses the fast or slow rate, the parity sense, the source of bit 32 and a self-test loopback. The self-test loopback copies the line outputs to two receiver-side output pairs. A bit-clock output shows the chosen master-clock division. A ready flag reports when the queue is empty and no word is on the line.

Top module: `a429_tx_queue`

## Requirements
- R1: While `rst_n` is low and right after it rises, `tx_ready` is 1 and `line_one`, `line_zero` and all four loopback outputs are 0. The control register resets to 4'b1100, which selects the fast rate, odd parity, parity in bit 32 and self-test off.
- R2: `cfg_wr` high at a clock edge loads `host_data[3:0]` into the control register. Bit 0 is the slow rate, bit 1 is even parity, bit 2 selects parity for bit 32 and bit 3 is self-test, active low. `bit_clk` has a period of FAST_DIV clocks (10), or SLOW_DIV clocks (80) when bit 0 is set, and is high for the first half of each period.
- R3: A `load_lo` strobe latches `host_data` as word bits [15:0]. A later `load_hi` strobe takes `host_data[14:0]` as bits [30:16] and `host_data[15]` as the data bit 32, and commits the word to the queue. A `load_hi` with no pending `load_lo` is ignored. `tx_ready` is 0 from the edge after a commit.
- R4: The queue holds DEPTH (8) words. A commit while it is full is dropped, and the first eight words are the ones sent.
- R5: Word bit 0 is sent first, as ARINC bit 1. Each bit is a pulse of DIV/2 clocks on `line_one` (for 1) or `line_zero` (for 0), followed by DIV/2 clocks with both outputs low. The first pulse starts at the clock edge that samples `tx_en` high while the queue is not empty and the block is idle.
- R6: While `tx_en` stays high, the next word's first pulse begins DIV/2 + 4*DIV clocks after the last pulse of the previous word ends.
- R7: When bit 32 carries parity, it makes the count of ones over all 32 bits odd if control bit 1 is 0, and even if control bit 1 is 1.
- R8: When `par_pin` is high, bit 32 is always parity. When `par_pin` is low, control bit 2 picks parity (1) or the committed data bit 32 (0).
- R9: `tx_ready` is 1 exactly when the queue is empty and no bit pulse or bit null phase is in progress. After the last queued word, it rises DIV/2 clocks after the last pulse ends.
- R10: If `tx_en` falls during a word, the line goes to null at the next edge and the rest of that word is discarded. The next enable starts with the following queued word.
- R11: With control bit 3 at 0, `rx1_one`/`rx1_zero` follow `line_one`/`line_zero`, `rx2_one`/`rx2_zero` follow `line_zero`/`line_one`, and transmission carries on normally. With bit 3 at 1, all four loopback outputs are 0.
- R12: A low `rst_n` stops transmission at once and empties the queue. With `tx_en` high after release, nothing is sent.
- R13: `line_one` and `line_zero` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| host_data | input | 16 | Host bus: control bits or word halves |
| cfg_wr | input | 1 | Control register write strobe |
| load_lo | input | 1 | Latch low half of a word |
| load_hi | input | 1 | Latch high half and commit the word |
| tx_en | input | 1 | Transmission enable |
| par_pin | input | 1 | High forces parity into bit 32 |
| line_one | output | 1 | Pulse output for ONE bits |
| line_zero | output | 1 | Pulse output for ZERO bits |
| bit_clk | output | 1 | Master clock divided by the selected rate |
| tx_ready | output | 1 | Queue empty and line not in a word |
| rx1_one | output | 1 | Self-test loopback to receiver 1, ONE input |
| rx1_zero | output | 1 | Self-test loopback to receiver 1, ZERO input |
| rx2_one | output | 1 | Self-test loopback to receiver 2, ONE input (swapped) |
| rx2_zero | output | 1 | Self-test loopback to receiver 2, ZERO input (swapped) |

## Verification
A commit shows on `tx_ready` one edge after the `load_hi` strobe. The first pulse appears one edge after `tx_en` is sampled high. `tx_ready` rises exactly DIV/2 clocks after the final pulse of the last word, and reset acts without waiting for a clock. The bench drives and samples one nanosecond after each falling clock edge, and a line monitor measures every pulse, every null phase and every gap in master clocks. The checks therefore name the exact sample at which a result is due, including one sample before and one at the rise of the ready flag.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
   localparam int WORD_BITS = 32;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_MARK  = 2'd1,
      SQ_SPACE = 2'd2,
      SQ_GAP   = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic selftest_n;
      logic bit32_par;
      logic par_even;
      logic rate_slow;
   } tx_cfg_t;
endpackage

// File: rtl/a429_load_seq.sv
module a429_load_seq
   import a429_tx_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [15:0]          host_data,
   input  logic                 load_lo,
   input  logic                 load_hi,
   output logic                 push,
   output logic [WORD_BITS-1:0] push_word
);
   logic [15:0] lo_q;
   logic        armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         armed_q <= 1'b0;
      end else if (load_lo) begin
         lo_q    <= host_data;
         armed_q <= 1'b1;
      end else if (load_hi) begin
         armed_q <= 1'b0;
      end
   end

   // low-half strobe has priority when both arrive together
   assign push      = load_hi && !load_lo && armed_q;
   assign push_word = {host_data, lo_q};
endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty
);
   localparam int  PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CNTW = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]    mem [DEPTH];
   logic [PW-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNTW-1:0] count;
   logic            full, do_push, do_pop;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign full    = (count == CNTW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         unique case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNTW'(DEPTH));

   assert_full_drops_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> $stable(count));
endmodule

// File: rtl/a429_bit32_gen.sv
module a429_bit32_gen
   import a429_tx_pkg::*;
(
   input  logic [WORD_BITS-1:0] word_in,
   input  logic                 par_even,
   input  logic                 bit32_par,
   input  logic                 par_pin,
   output logic [WORD_BITS-1:0] framed
);
   logic ones_odd, par_bit, use_par;

   assign ones_odd = ^word_in[WORD_BITS-2:0];
   // odd sense: bit 32 tops up an even count of ones
   assign par_bit  = par_even ? ones_odd : ~ones_odd;
   assign use_par  = par_pin || bit32_par;
   assign framed   = {use_par ? par_bit : word_in[WORD_BITS-1], word_in[WORD_BITS-2:0]};
endmodule

// File: rtl/a429_serializer.sv
module a429_serializer
   import a429_tx_pkg::*;
#(
   parameter int FAST_DIV = 10,
   parameter int SLOW_DIV = 80
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_en,
   input  logic                 rate_slow,
   input  logic                 fifo_empty,
   input  logic [WORD_BITS-1:0] frame,
   output logic                 pop,
   output logic                 line_one,
   output logic                 line_zero,
   output logic                 busy
);
   localparam int CW = $clog2(4 * SLOW_DIV);
   localparam int BW = $clog2(WORD_BITS);

   seq_state_t           st;
   logic [CW-1:0]        cnt, half_lim, gap_lim;
   logic [BW-1:0]        bit_idx;
   logic [WORD_BITS-1:0] sh;
   logic                 start_ok, gap_done;

   assign half_lim = rate_slow ? CW'(SLOW_DIV / 2 - 1) : CW'(FAST_DIV / 2 - 1);
   assign gap_lim  = rate_slow ? CW'(4 * SLOW_DIV - 1) : CW'(4 * FAST_DIV - 1);
   assign start_ok = tx_en && !fifo_empty;
   assign gap_done = (st == SQ_GAP) && (cnt >= gap_lim);
   assign pop      = start_ok && ((st == SQ_IDLE) || gap_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         sh      <= '0;
      end else begin
         unique case (st)
            SQ_IDLE: begin
               cnt <= '0;
               if (start_ok) begin
                  st      <= SQ_MARK;
                  sh      <= frame;
                  bit_idx <= '0;
               end
            end
            SQ_MARK: begin
               if (!tx_en) begin
                  st  <= SQ_IDLE;
                  cnt <= '0;
               end else if (cnt >= half_lim) begin
                  st  <= SQ_SPACE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQ_SPACE: begin
               if (!tx_en) begin
                  st  <= SQ_IDLE;
                  cnt <= '0;
               end else if (cnt >= half_lim) begin
                  cnt <= '0;
                  if (bit_idx == BW'(WORD_BITS - 1)) begin
                     st <= SQ_GAP;
                  end else begin
                     st      <= SQ_MARK;
                     bit_idx <= bit_idx + 1'b1;
                     sh      <= {1'b0, sh[WORD_BITS-1:1]};
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQ_GAP: begin
               if (gap_done) begin
                  cnt <= '0;
                  if (start_ok) begin
                     st      <= SQ_MARK;
                     sh      <= frame;
                     bit_idx <= '0;
                  end else begin
                     st <= SQ_IDLE;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign line_one  = (st == SQ_MARK) && sh[0];
   assign line_zero = (st == SQ_MARK) && !sh[0];
   assign busy      = (st == SQ_MARK) || (st == SQ_SPACE);

   assert_lines_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_one && line_zero));

   assert_pulse_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_MARK && cnt != '0) |-> ($stable(line_one) && $stable(line_zero)));
endmodule

// File: rtl/a429_tx_queue.sv
module a429_tx_queue
   import a429_tx_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int FAST_DIV = 10,
   parameter int SLOW_DIV = 80
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] host_data,
   input  logic        cfg_wr,
   input  logic        load_lo,
   input  logic        load_hi,
   input  logic        tx_en,
   input  logic        par_pin,
   output logic        line_one,
   output logic        line_zero,
   output logic        bit_clk,
   output logic        tx_ready,
   output logic        rx1_one,
   output logic        rx1_zero,
   output logic        rx2_one,
   output logic        rx2_zero
);
   localparam int         DW        = $clog2(SLOW_DIV);
   localparam logic [3:0] CFG_RESET = 4'b1100;

   generate
      if (FAST_DIV < 2 || (FAST_DIV % 2) != 0) begin : g_bad_fast
         $error("FAST_DIV must be even and at least 2");
      end
      if (SLOW_DIV <= FAST_DIV || (SLOW_DIV % 2) != 0) begin : g_bad_slow
         $error("SLOW_DIV must be even and above FAST_DIV");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   tx_cfg_t              cfg_q;
   logic [DW-1:0]        div_cnt, div_last, div_half;
   logic                 push, pop, fifo_empty, ser_busy;
   logic [WORD_BITS-1:0] push_word, head_word, frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= tx_cfg_t'(CFG_RESET);
      else if (cfg_wr) cfg_q <= tx_cfg_t'(host_data[3:0]);
   end

   assign div_last = cfg_q.rate_slow ? DW'(SLOW_DIV - 1) : DW'(FAST_DIV - 1);
   assign div_half = cfg_q.rate_slow ? DW'(SLOW_DIV / 2) : DW'(FAST_DIV / 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  div_cnt <= '0;
      else if (div_cnt >= div_last) div_cnt <= '0;
      else                          div_cnt <= div_cnt + 1'b1;
   end
   assign bit_clk = (div_cnt < div_half);

   a429_load_seq u_load (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_data (host_data),
      .load_lo   (load_lo),
      .load_hi   (load_hi),
      .push      (push),
      .push_word (push_word)
   );

   a429_word_fifo #(.DEPTH(DEPTH), .W(WORD_BITS)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (push_word),
      .pop   (pop),
      .rdata (head_word),
      .empty (fifo_empty)
   );

   a429_bit32_gen u_b32 (
      .word_in   (head_word),
      .par_even  (cfg_q.par_even),
      .bit32_par (cfg_q.bit32_par),
      .par_pin   (par_pin),
      .framed    (frame)
   );

   a429_serializer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_en      (tx_en),
      .rate_slow  (cfg_q.rate_slow),
      .fifo_empty (fifo_empty),
      .frame      (frame),
      .pop        (pop),
      .line_one   (line_one),
      .line_zero  (line_zero),
      .busy       (ser_busy)
   );

   assign tx_ready = fifo_empty && !ser_busy;
   assign rx1_one  = !cfg_q.selftest_n && line_one;
   assign rx1_zero = !cfg_q.selftest_n && line_zero;
   assign rx2_one  = !cfg_q.selftest_n && line_zero;
   assign rx2_zero = !cfg_q.selftest_n && line_one;

   assert_ready_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !ser_busy) |=> !tx_ready);
endmodule

// File: tb/test_a429_tx_queue.sv
`timescale 1ns/1ps
module test_a429_tx_queue;
   localparam int FAST = 10;
   localparam int SLOW = 80;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [15:0] host_data = '0;
   logic        cfg_wr = 1'b0, load_lo = 1'b0, load_hi = 1'b0, tx_en = 1'b0, par_pin = 1'b1;
   logic        line_one, line_zero, bit_clk, tx_ready, rx1_one, rx1_zero, rx2_one, rx2_zero;

   a429_tx_queue i_a429_tx_queue (
      .clk(clk), .rst_n(rst_n), .host_data(host_data), .cfg_wr(cfg_wr),
      .load_lo(load_lo), .load_hi(load_hi), .tx_en(tx_en), .par_pin(par_pin),
      .line_one(line_one), .line_zero(line_zero), .bit_clk(bit_clk), .tx_ready(tx_ready),
      .rx1_one(rx1_one), .rx1_zero(rx1_zero), .rx2_one(rx2_one), .rx2_zero(rx2_zero)
   );

   always #10 clk = ~clk;

   int   n_run = 0, n_fail = 0;
   int   cur_half = FAST / 2;
   logic mon_clr = 1'b0, st_mode = 1'b0;

   // line monitor
   int          mon_run = 0, mon_null = 0, mon_bits = 0, cur_gap = 0, n_cap = 0;
   int          tim_err = 0, both_err = 0, leak_err = 0, loop_err = 0, act_samples = 0;
   logic        mon_prev = 1'b0, mon_val = 1'b0;
   logic [31:0] mon_acc = '0;
   logic [31:0] cap_word [0:255];
   int          cap_gap  [0:255];

   always @(negedge clk) begin
      if (line_one && line_zero) both_err++;
      if (line_one || line_zero) act_samples++;
      if (!st_mode && (rx1_one || rx1_zero || rx2_one || rx2_zero)) leak_err++;
      if (st_mode && (rx1_one !== line_one || rx1_zero !== line_zero ||
                      rx2_one !== line_zero || rx2_zero !== line_one)) loop_err++;
      if (!rst_n || mon_clr) begin
         mon_run = 0; mon_null = 0; mon_bits = 0; mon_prev = 1'b0;
      end else if (line_one || line_zero) begin
         if (!mon_prev) begin
            if (mon_bits != 0 && mon_null != cur_half) tim_err++;
            if (mon_bits == 0) cur_gap = mon_null;
            mon_run = 0;
            mon_val = line_one;
         end
         mon_run++;
         mon_prev = 1'b1;
      end else begin
         if (mon_prev) begin
            if (mon_run != cur_half) tim_err++;
            mon_acc[mon_bits] = mon_val;
            mon_bits++;
            if (mon_bits == 32) begin
               if (n_cap < 256) begin
                  cap_word[n_cap] = mon_acc;
                  cap_gap[n_cap]  = cur_gap;
               end
               n_cap++;
               mon_bits = 0;
            end
            mon_null = 0;
         end
         mon_null++;
         mon_prev = 1'b0;
      end
   end

   function automatic logic [31:0] frame_of(logic [31:0] w, logic pin, logic b32p, logic even);
      logic p;
      p = ^w[30:0];
      if (!even) p = ~p;
      return {(pin || b32p) ? p : w[31], w[30:0]};
   endfunction

   task automatic tick(int n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic chk(string req, longint act, longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_cfg(logic slow, logic even, logic b32p, logic stn);
      host_data = {12'd0, stn, b32p, even, slow};
      cfg_wr = 1'b1;
      tick(1);
      cfg_wr = 1'b0;
      host_data = '0;
      cur_half = slow ? SLOW / 2 : FAST / 2;
      st_mode = !stn;
   endtask

   task automatic load_word(logic [31:0] w);
      host_data = w[15:0];
      load_lo = 1'b1;
      tick(1);
      load_lo = 1'b0;
      host_data = w[31:16];
      load_hi = 1'b1;
      tick(1);
      load_hi = 1'b0;
      host_data = '0;
   endtask

   task automatic wait_caps(int target, int limit);
      int k = 0;
      while (n_cap < target && k < limit) begin
         tick(1);
         k++;
      end
   endtask

   task automatic measure_clk(int div);
      int hi = 0, lo = 0, k = 0;
      while (bit_clk != 1'b0 && k < 200) begin tick(1); k++; end
      while (bit_clk != 1'b1 && k < 400) begin tick(1); k++; end
      while (bit_clk == 1'b1 && hi < 200) begin hi++; tick(1); end
      while (bit_clk == 1'b0 && lo < 200) begin lo++; tick(1); end
      chk("R2 bit_clk high", hi, div / 2);
      chk("R2 bit_clk low", lo, div / 2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] words [0:8];
      int base;
      void'($urandom(32'd4242));
      tick(3);
      // R1 during and after reset
      chk("R1 ready in reset", tx_ready, 1);
      chk("R1 lines in reset", {line_one, line_zero}, 0);
      rst_n = 1'b1;
      tick(2);
      chk("R1 ready after reset", tx_ready, 1);
      chk("R1 loopback idle", {rx1_one, rx1_zero, rx2_one, rx2_zero}, 0);

      // R2 bit clock at both rates
      measure_clk(FAST);
      write_cfg(1'b1, 1'b0, 1'b1, 1'b1);
      tick(100);
      measure_clk(SLOW);
      write_cfg(1'b0, 1'b0, 1'b1, 1'b1);

      // R3 lone high-half strobe is ignored
      host_data = 16'hABCD;
      load_hi = 1'b1;
      tick(1);
      load_hi = 1'b0;
      tick(2);
      chk("R3 lone load_hi ignored", tx_ready, 1);

      // R3 commit drops ready, R5 first-bit latency
      par_pin = 1'b1;
      base = n_cap;
      host_data = 16'h0001;
      load_lo = 1'b1;
      tick(1);
      load_lo = 1'b0;
      host_data = 16'h1234;
      load_hi = 1'b1;
      tick(1);
      load_hi = 1'b0;
      chk("R3 ready low after commit", tx_ready, 0);
      tx_en = 1'b1;
      chk("R5 idle before enable edge", {line_one, line_zero}, 0);
      tick(1);
      chk("R5 first bit one edge after enable", {line_one, line_zero}, 2'b10);
      wait_caps(base + 1, 500);
      chk("R9 ready low in last null", tx_ready, 0);
      tick(cur_half - 1);
      chk("R9 ready still low", tx_ready, 0);
      tick(1);
      chk("R9 ready rises after last null", tx_ready, 1);
      chk("R7 odd parity word", cap_word[base], frame_of(32'h1234_0001, 1'b1, 1'b1, 1'b0));
      tx_en = 1'b0;
      tick(60);

      // R6 R7 R8 directed and random bursts
      for (int b = 0; b < 12; b++) begin
         logic ev, bp, pp;
         int n;
         if (b < 4) begin
            ev = (b == 1);
            pp = (b < 2);
            bp = (b == 3);
            n = 3;
         end else begin
            ev = 1'($urandom % 2);
            bp = 1'($urandom % 2);
            pp = 1'($urandom % 2);
            n = 1 + int'($urandom % 8);
         end
         write_cfg(1'b0, ev, bp, 1'b1);
         par_pin = pp;
         base = n_cap;
         for (int k = 0; k < n; k++) begin
            if (b < 4) words[k] = (k == 0) ? 32'h0 : (k == 1) ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
            else       words[k] = $urandom;
            load_word(words[k]);
         end
         tx_en = 1'b1;
         wait_caps(base + n, n * 400 + 100);
         tx_en = 1'b0;
         tick(5);
         chk("R4 words sent in burst", n_cap - base, n);
         for (int k = 0; k < n; k++) begin
            if (pp || bp) chk("R7 parity bit32", cap_word[base + k], frame_of(words[k], pp, bp, ev));
            else          chk("R8 data bit32", cap_word[base + k], frame_of(words[k], pp, bp, ev));
         end
         for (int k = 1; k < n; k++)
            chk("R6 word gap", cap_gap[base + k], FAST / 2 + 4 * FAST);
      end

      // R4 overflow
      write_cfg(1'b0, 1'b0, 1'b1, 1'b1);
      par_pin = 1'b1;
      base = n_cap;
      for (int k = 0; k < 9; k++) begin
         words[k] = 32'h0101_0101 * (k + 1);
         load_word(words[k]);
      end
      tx_en = 1'b1;
      wait_caps(base + 8, 4000);
      tick(800);
      chk("R4 ninth word dropped", n_cap - base, 8);
      for (int k = 0; k < 8; k++)
         chk("R4 kept order", cap_word[base + k], frame_of(words[k], 1'b1, 1'b1, 1'b0));
      chk("R9 ready after burst", tx_ready, 1);
      tx_en = 1'b0;
      tick(5);

      // R10 enable dropped mid word
      base = n_cap;
      load_word(32'h5555_AAAA);
      load_word(32'h0F0F_3C3C);
      tx_en = 1'b1;
      tick(100);
      tx_en = 1'b0;
      mon_clr = 1'b1;
      tick(1);
      chk("R10 line null after drop", {line_one, line_zero}, 0);
      chk("R10 next word still queued", tx_ready, 0);
      tick(2);
      mon_clr = 1'b0;
      tx_en = 1'b1;
      wait_caps(base + 1, 600);
      tick(600);
      chk("R10 only next word sent", n_cap - base, 1);
      chk("R10 resumed with next word", cap_word[base], frame_of(32'h0F0F_3C3C, 1'b1, 1'b1, 1'b0));
      chk("R10 ready after resume", tx_ready, 1);
      tx_en = 1'b0;
      tick(5);

      // R11 self-test loopback
      write_cfg(1'b0, 1'b0, 1'b1, 1'b0);
      base = n_cap;
      load_word(32'h2468_ACE1);
      tx_en = 1'b1;
      wait_caps(base + 1, 600);
      tx_en = 1'b0;
      tick(5);
      chk("R11 lines active in self test", cap_word[base], frame_of(32'h2468_ACE1, 1'b1, 1'b1, 1'b0));
      write_cfg(1'b0, 1'b0, 1'b1, 1'b1);
      chk("R11 loopback mismatches", loop_err, 0);
      chk("R11 loopback leak when off", leak_err, 0);

      // slow rate: R5 timing and R6 gap at divide-by-80
      write_cfg(1'b1, 1'b1, 1'b1, 1'b1);
      base = n_cap;
      load_word(32'h1357_9BDF);
      load_word(32'h8000_0001);
      tx_en = 1'b1;
      wait_caps(base + 2, 7000);
      tx_en = 1'b0;
      tick(5);
      chk("R7 even parity slow", cap_word[base], frame_of(32'h1357_9BDF, 1'b1, 1'b1, 1'b1));
      chk("R7 even parity slow second", cap_word[base + 1], frame_of(32'h8000_0001, 1'b1, 1'b1, 1'b1));
      chk("R6 slow word gap", cap_gap[base + 1], SLOW / 2 + 4 * SLOW);
      write_cfg(1'b0, 1'b0, 1'b1, 1'b1);
      chk("R5 pulse and null timing", tim_err, 0);

      // R12 master reset mid transmission
      load_word(32'h1111_1111);
      load_word(32'h2222_2222);
      load_word(32'h3333_3333);
      tx_en = 1'b1;
      tick(150);
      rst_n = 1'b0;
      #1;
      chk("R12 lines stop at reset", {line_one, line_zero}, 0);
      chk("R12 ready at reset", tx_ready, 1);
      tick(2);
      rst_n = 1'b1;
      base = act_samples;
      tick(600);
      chk("R12 nothing sent after reset", act_samples - base, 0);
      chk("R12 queue empty", tx_ready, 1);
      tx_en = 1'b0;
      chk("R13 lines never both high", both_err, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule